// File: doc/BRIEF.md
# Legacy Address Range Routing Decoder

This block sits beside a host bridge and picks a destination for every CPU-initiated memory or I/O request. It holds an 8-bit control register and reads the live settings of a downstream PCI Express bridge port: VGA enable, memory and I/O access enables, and an I/O base/limit window. Requests in the legacy display ranges go either to the legacy south port or to the PCI Express port. I/O requests outside those ranges are steered by the bridge I/O window. Memory requests outside them are DRAM hits, unless the optional 15–16 MB hole is enabled and the address falls inside it.

Each request is a valid strobe with an address, a memory/I/O flag and a byte count. One clock later the block presents the route, a hole flag and a response strobe. A configuration-error flag tracks the one illegal pairing of the control register and the bridge VGA enable. The DRAM behind the hole is never remapped. Hole accesses are sent to the south port.

Top module: `legacy_route_top`

## Requirements
- R1: The control register resets to 8'h00. Bit 7 enables the hole and bit 0 declares the monochrome display adapter (MDA) as present. A write stores only bits 7 and 0, and bits 6:1 always read 0. `ctl_rdata_o` changes only after a write.
- R2: A request sampled with `req_valid_i` high gives `rsp_valid_o` high in the next cycle, together with `route_o` and `hole_o`. `rsp_valid_o` is low in every other cycle. Route codes are 0 = DRAM, 1 = south port and 2 = PCI Express. After reset, all outputs are 0.
- R3: With the hole enabled, memory addresses 0xF00000 through 0xFFFFFF give route 1 with `hole_o` = 1. With the hole disabled, or at 0xEFFFFF or 0x1000000, the route is 0 and `hole_o` is 0. I/O requests never raise `hole_o`.
- R4: Memory from 0xA0000 to 0xBFFFF goes to PCI Express when VGA enable and the memory access enable are both 1. With the memory access enable at 0, it goes to the south port.
- R5: When VGA enable is 1 and MDA-present is 1, memory from 0xB0000 to 0xB7FFF goes to the south port, while 0xB8000 still follows R4.
- R6: When VGA enable is 0, every legacy display memory or I/O request goes to the south port.
- R7: When VGA enable is 0 and MDA-present is 1, `cfg_err_o` is 1, one cycle after the setting is visible. Legacy requests then go to the south port.
- R8: When VGA enable is 1 and MDA-present is 1, an I/O request whose bytes cover any of the ports 0x3B4, 0x3B5, 0x3B8, 0x3B9, 0x3BA or 0x3BF goes to the south port. The match uses address bits [9:0] only, so aliases also hit. The request covers `req_size_i`+1 bytes, starting at the address.
- R9: When VGA enable is 1, an I/O request that covers 0x3BC–0x3BF (aliased) and no MDA port under R8 goes to PCI Express only if the I/O access enable is 1 and every byte lies within [`io_base_i`, `io_limit_i`]. Otherwise it goes to the south port.
- R10: When VGA enable is 1, other display I/O bytes (0x3B0–0x3BB and 0x3C0–0x3DF, aliased) go to PCI Express if the I/O access enable is 1, and to the south port if it is 0.
- R11: An I/O request that covers no legacy port goes to PCI Express when the I/O access enable is 1 and all of its bytes lie inside the window. Otherwise it goes to the south port. Memory outside the display range and the hole goes to DRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register read data |
| vga_en_i | input | 1 | Bridge VGA enable |
| mem_en_i | input | 1 | Bridge memory access enable |
| io_en_i | input | 1 | Bridge I/O access enable |
| io_base_i | input | 16 | Bridge I/O window base (inclusive) |
| io_limit_i | input | 16 | Bridge I/O window limit (inclusive) |
| req_valid_i | input | 1 | Request strobe |
| req_is_io_i | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr_i | input | 32 | Request address; I/O uses bits [15:0] |
| req_size_i | input | 2 | Byte count minus one |
| rsp_valid_o | output | 1 | Decision strobe |
| route_o | output | 2 | Destination: 0 DRAM, 1 south, 2 PCI Express |
| hole_o | output | 1 | Memory request fell in the enabled hole |
| cfg_err_o | output | 1 | MDA present while VGA enable is 0 |

## Verification
The assertions assume that the bridge enables and the window stay steady during the cycle in which a request is sampled. They also assume that a register write never lands in the same cycle as a request that relies on the new value. The stimulus changes settings only at falling edges before it raises the strobe, and it places every register write one full cycle ahead of the request that follows it. Memory requests are decoded on the start address, so the bench uses single-location memory requests. It keeps multi-byte spans for I/O.

// File: rtl/legacy_route_pkg.sv
package legacy_route_pkg;
  typedef enum logic [1:0] {
    RT_DRAM  = 2'd0,
    RT_SOUTH = 2'd1,
    RT_PCIE  = 2'd2
  } route_e;

  localparam int unsigned CTL_W        = 8;
  localparam int unsigned CTL_HEN_BIT  = 7;
  localparam int unsigned CTL_MDAP_BIT = 0;
  localparam logic [CTL_W-1:0] CTL_WMASK = 8'h81;

  localparam logic [31:0] VGA_MEM_LO = 32'h000A_0000;
  localparam logic [31:0] VGA_MEM_HI = 32'h000B_FFFF;
  localparam logic [31:0] MDA_MEM_LO = 32'h000B_0000;
  localparam logic [31:0] MDA_MEM_HI = 32'h000B_7FFF;
  localparam logic [31:0] HOLE_LO    = 32'h00F0_0000;
  localparam logic [31:0] HOLE_HI    = 32'h00FF_FFFF;

  localparam int unsigned ALIAS_W = 10;
endpackage

// File: rtl/legacy_ctl_reg.sv
module legacy_ctl_reg
  import legacy_route_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic [CTL_W-1:0] rdata_o,
  output logic             hole_en_o,
  output logic             mda_present_o
);
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (we_i) ctl_q <= wdata_i & CTL_WMASK;
  end

  assign rdata_o       = ctl_q;
  assign hole_en_o     = ctl_q[CTL_HEN_BIT];
  assign mda_present_o = ctl_q[CTL_MDAP_BIT];

  AST_CTL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rdata_o)); // R1
endmodule

// File: rtl/legacy_io_match.sv
module legacy_io_match
  import legacy_route_pkg::*;
#(
  parameter int unsigned IOW  = 16,
  parameter int unsigned MAXB = 4,
  localparam int unsigned SW  = (MAXB > 1) ? $clog2(MAXB) : 1
) (
  input  logic [IOW-1:0] addr_i,
  input  logic [SW-1:0]  size_i,
  output logic           hit_mda_o,
  output logic           hit_vga_o,
  output logic           hit_3bc_o,
  output logic [IOW-1:0] end_addr_o
);
  logic [MAXB-1:0] mda_b, vga_b, b3bc_b;

  for (genvar k = 0; k < MAXB; k++) begin : g_byte
    logic [IOW-1:0]     ba;
    logic [ALIAS_W-1:0] lo;
    logic               act;
    assign ba  = addr_i + IOW'(k);
    assign lo  = ba[ALIAS_W-1:0];
    assign act = (32'(size_i) >= k);
    assign mda_b[k] = act && (lo == 10'h3B4 || lo == 10'h3B5 || lo == 10'h3B8 ||
                              lo == 10'h3B9 || lo == 10'h3BA || lo == 10'h3BF);
    assign vga_b[k] = act && ((lo >= 10'h3B0 && lo <= 10'h3BB) ||
                              (lo >= 10'h3C0 && lo <= 10'h3DF));
    assign b3bc_b[k] = act && (lo >= 10'h3BC && lo <= 10'h3BF);
  end

  assign hit_mda_o  = |mda_b;
  assign hit_vga_o  = |vga_b;
  assign hit_3bc_o  = |b3bc_b;
  assign end_addr_o = addr_i + IOW'(size_i);
endmodule

// File: rtl/legacy_route_dec.sv
module legacy_route_dec
  import legacy_route_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned IOW  = 16,
  parameter int unsigned MAXB = 4,
  localparam int unsigned SW  = (MAXB > 1) ? $clog2(MAXB) : 1
) (
  input  logic           is_io_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [SW-1:0]  size_i,
  input  logic           hole_en_i,
  input  logic           mdap_i,
  input  logic           vga_en_i,
  input  logic           mem_en_i,
  input  logic           io_en_i,
  input  logic [IOW-1:0] io_base_i,
  input  logic [IOW-1:0] io_limit_i,
  output route_e         route_o,
  output logic           hole_o
);
  logic [IOW-1:0] io_addr, io_end;
  logic hit_mda, hit_vga, hit_3bc, in_win;
  logic in_vga_mem, in_mda_mem, in_hole;

  assign io_addr = addr_i[IOW-1:0];

  legacy_io_match #(.IOW(IOW), .MAXB(MAXB)) u_match (
    .addr_i     (io_addr),
    .size_i     (size_i),
    .hit_mda_o  (hit_mda),
    .hit_vga_o  (hit_vga),
    .hit_3bc_o  (hit_3bc),
    .end_addr_o (io_end)
  );

  // whole span inside the window, no wrap past the top of I/O space
  assign in_win = (io_addr >= io_base_i) && (io_end <= io_limit_i) && (io_end >= io_addr);

  assign in_vga_mem = (addr_i >= AW'(VGA_MEM_LO)) && (addr_i <= AW'(VGA_MEM_HI));
  assign in_mda_mem = (addr_i >= AW'(MDA_MEM_LO)) && (addr_i <= AW'(MDA_MEM_HI));
  assign in_hole    = (addr_i >= AW'(HOLE_LO))    && (addr_i <= AW'(HOLE_HI));

  always_comb begin
    route_o = RT_DRAM;
    hole_o  = 1'b0;
    if (is_io_i) begin
      if (hit_vga || hit_3bc) begin
        if (!vga_en_i || (mdap_i && hit_mda) || !io_en_i || (hit_3bc && !in_win))
          route_o = RT_SOUTH;
        else
          route_o = RT_PCIE;
      end else begin
        route_o = (io_en_i && in_win) ? RT_PCIE : RT_SOUTH;
      end
    end else if (in_vga_mem) begin
      if (!vga_en_i || (mdap_i && in_mda_mem) || !mem_en_i) route_o = RT_SOUTH;
      else                                                 route_o = RT_PCIE;
    end else if (hole_en_i && in_hole) begin
      route_o = RT_SOUTH;
      hole_o  = 1'b1;
    end
  end
endmodule

// File: rtl/legacy_route_top.sv
module legacy_route_top
  import legacy_route_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned IOW  = 16,
  parameter int unsigned MAXB = 4,
  localparam int unsigned SW  = (MAXB > 1) ? $clog2(MAXB) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [CTL_W-1:0] ctl_rdata_o,
  input  logic             vga_en_i,
  input  logic             mem_en_i,
  input  logic             io_en_i,
  input  logic [IOW-1:0]   io_base_i,
  input  logic [IOW-1:0]   io_limit_i,
  input  logic             req_valid_i,
  input  logic             req_is_io_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [SW-1:0]    req_size_i,
  output logic             rsp_valid_o,
  output logic [1:0]       route_o,
  output logic             hole_o,
  output logic             cfg_err_o
);
  logic   hole_en, mdap, dec_hole;
  route_e dec_route;

  legacy_ctl_reg u_ctl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (ctl_we_i),
    .wdata_i       (ctl_wdata_i),
    .rdata_o       (ctl_rdata_o),
    .hole_en_o     (hole_en),
    .mda_present_o (mdap)
  );

  legacy_route_dec #(.AW(AW), .IOW(IOW), .MAXB(MAXB)) u_dec (
    .is_io_i    (req_is_io_i),
    .addr_i     (req_addr_i),
    .size_i     (req_size_i),
    .hole_en_i  (hole_en),
    .mdap_i     (mdap),
    .vga_en_i   (vga_en_i),
    .mem_en_i   (mem_en_i),
    .io_en_i    (io_en_i),
    .io_base_i  (io_base_i),
    .io_limit_i (io_limit_i),
    .route_o    (dec_route),
    .hole_o     (dec_hole)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      route_o     <= RT_DRAM;
      hole_o      <= 1'b0;
      cfg_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      cfg_err_o   <= mdap & ~vga_en_i;
      if (req_valid_i) begin
        route_o <= dec_route;
        hole_o  <= dec_hole;
      end
    end
  end

  AST_RSP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R2
  AST_RSP_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R2
  AST_HOLE_TO_SOUTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && hole_o) |-> (route_o == RT_SOUTH)); // R3
  AST_IO_NO_HOLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_is_io_i) |=> !hole_o); // R3
  AST_NOVGA_MEM_NOT_PCIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_is_io_i && !vga_en_i) |=> (route_o != RT_PCIE)); // R6
  AST_PCIE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && dec_route == RT_PCIE) |-> (req_is_io_i ? io_en_i : mem_en_i)); // R10
endmodule

// File: tb/sim_legacy_route_top.sv
module sim_legacy_route_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        io;
    logic [31:0] addr;
    logic [1:0]  sz;
    logic [7:0]  ctl;
    logic        vga;
    logic        men;
    logic        ien;
    logic [1:0]  rt;
    logic        hole;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0010_0000, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd11}, // R11
    '{1'b0, 32'h00F0_0000, 2'd0, 8'h80, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 4'd3},  // R3
    '{1'b0, 32'h00FF_FFFF, 2'd0, 8'h80, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 4'd3},  // R3
    '{1'b0, 32'h0100_0000, 2'd0, 8'h80, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd3},  // R3
    '{1'b0, 32'h00EF_FFFF, 2'd0, 8'h80, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd3},  // R3
    '{1'b0, 32'h00F0_0000, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd3},  // R3
    '{1'b0, 32'h000A_0000, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 4'd4},  // R4
    '{1'b0, 32'h000B_FFFF, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 4'd4},  // R4
    '{1'b0, 32'h000B_0000, 2'd0, 8'h01, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 4'd5},  // R5
    '{1'b0, 32'h000B_7FFF, 2'd0, 8'h01, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 4'd5},  // R5
    '{1'b0, 32'h000B_8000, 2'd0, 8'h01, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 4'd5},  // R5
    '{1'b0, 32'h000A_0000, 2'd0, 8'h00, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 4'd6},  // R6
    '{1'b1, 32'h0000_03B4, 2'd0, 8'h00, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 4'd6},  // R6
    '{1'b1, 32'h0000_03BC, 2'd0, 8'h00, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 4'd6},  // R6
    '{1'b1, 32'h0000_03B4, 2'd0, 8'h01, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 4'd8},  // R8
    '{1'b1, 32'h0000_7FB8, 2'd0, 8'h01, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 4'd8},  // R8 alias
    '{1'b1, 32'h0000_03B6, 2'd1, 8'h01, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 4'd10}, // R10
    '{1'b1, 32'h0000_03B6, 2'd3, 8'h01, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 4'd8},  // R8 span
    '{1'b1, 32'h0000_03BC, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 4'd9},  // R9
    '{1'b1, 32'h0000_03BC, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 4'd9},  // R9
    '{1'b1, 32'h0000_03C0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 4'd10}, // R10
    '{1'b1, 32'h0000_03DF, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 4'd10}, // R10
    '{1'b1, 32'h0000_0380, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 4'd11}, // R11
    '{1'b1, 32'h0000_0200, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 4'd11}, // R11
    '{1'b0, 32'h000A_0000, 2'd0, 8'h01, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 4'd7},  // R7
    '{1'b1, 32'h0000_7BC0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 4'd10}, // R10 alias
    '{1'b1, 32'h0000_03BF, 2'd0, 8'h00, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 4'd9},  // R9
    '{1'b1, 32'h0000_03BF, 2'd0, 8'h01, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 4'd8}   // R8
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0, ctl_rdata;
  logic        vga_en = 1'b0, mem_en = 1'b0, io_en = 1'b0;
  logic [15:0] io_base = 16'h0300, io_limit = 16'h03FF;
  logic        req_valid = 1'b0, req_is_io = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        rsp_valid, hole, cfg_err;
  logic [1:0]  route;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  legacy_route_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata),
    .vga_en_i(vga_en), .mem_en_i(mem_en), .io_en_i(io_en),
    .io_base_i(io_base), .io_limit_i(io_limit),
    .req_valid_i(req_valid), .req_is_io_i(req_is_io),
    .req_addr_i(req_addr), .req_size_i(req_size),
    .rsp_valid_o(rsp_valid), .route_o(route), .hole_o(hole), .cfg_err_o(cfg_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  // raise strobe at a falling edge, sample one falling edge later
  task automatic do_req(input logic io, input logic [31:0] a, input logic [1:0] sz);
    req_is_io = io; req_addr = a; req_size = sz; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ctl", 32'(ctl_rdata), 32'h00);
    chk("R2 reset rsp_valid", 32'(rsp_valid), 0);
    chk("R2 reset route", 32'(route), 0);
    chk("R2 reset hole", 32'(hole), 0);
    chk("R7 reset err", 32'(cfg_err), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vga_en = VECS[i].vga; mem_en = VECS[i].men; io_en = VECS[i].ien;
      wr_ctl(VECS[i].ctl);
      do_req(VECS[i].io, VECS[i].addr, VECS[i].sz);
      chk($sformatf("R%0d vec %0d valid", VECS[i].rq, i), 32'(rsp_valid), 1);
      chk($sformatf("R%0d vec %0d route", VECS[i].rq, i), 32'(route), 32'(VECS[i].rt));
      chk($sformatf("R%0d vec %0d hole", VECS[i].rq, i), 32'(hole), 32'(VECS[i].hole));
    end

    // R2: no strobe, no response
    @(negedge clk);
    chk("R2 idle rsp_valid", 32'(rsp_valid), 0);

    // R1: reserved bits dropped
    wr_ctl(8'hFF);
    chk("R1 reserved masked", 32'(ctl_rdata), 32'h81);
    repeat (2) @(negedge clk);
    chk("R1 hold w/o write", 32'(ctl_rdata), 32'h81);
    wr_ctl(8'h7E);
    chk("R1 reserved only", 32'(ctl_rdata), 32'h00);

    // R7: illegal pairing flagged, legacy I/O to south
    vga_en = 1'b0; io_en = 1'b1; mem_en = 1'b1;
    wr_ctl(8'h01);
    do_req(1'b1, 32'h0000_03BC, 2'd0);
    chk("R7 err flag", 32'(cfg_err), 1);
    chk("R7 io route", 32'(route), 1);
    vga_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 err clears", 32'(cfg_err), 0);

    // R9: window edges on 0x3BC..0x3BF
    wr_ctl(8'h00);
    io_base = 16'h03BD; io_limit = 16'h03FF;
    do_req(1'b1, 32'h0000_03BC, 2'd0);
    chk("R9 below base", 32'(route), 1);
    do_req(1'b1, 32'h0000_03BB, 2'd1);
    chk("R9 span below base", 32'(route), 1);
    do_req(1'b1, 32'h0000_03BD, 2'd1);
    chk("R9 inside window", 32'(route), 2);
    io_limit = 16'h03BE;
    do_req(1'b1, 32'h0000_03BD, 2'd2);
    chk("R9 past limit", 32'(route), 1);

    // R11: span crossing the window top
    io_base = 16'h0300; io_limit = 16'h0381;
    do_req(1'b1, 32'h0000_0380, 2'd3);
    chk("R11 span past limit", 32'(route), 1);
    do_req(1'b1, 32'h0000_0380, 2'd1);
    chk("R11 span inside", 32'(route), 2);

    // R3: I/O at hole address range never flags hole
    io_base = 16'h0000; io_limit = 16'hFFFF;
    wr_ctl(8'h80);
    do_req(1'b1, 32'h00F0_0000, 2'd0);
    chk("R3 io no hole", 32'(hole), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule